// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit turns a decoded operand specifier into an operand value. A specifier has three parts: a 3-bit mode, a field that holds either a constant or an address, and a register selector. The unit reads the register file through a combinational read port. It reads memory through a single-port read channel that uses a one-cycle request strobe and a read-valid response, and the read latency may vary. For each mode it forms the effective address and issues zero, one or two dependent memory reads. It then returns the operand, the final effective address and the number of memory accesses it made.

Address arithmetic uses the address width and discards the carry, so an address wraps modulo the address space. The register value is added as a two's-complement number, so a negative index steps backwards from the base. A start pulse begins an operation. A one-cycle done pulse marks the results as valid.

Top module: `opnd_fetch`

## Requirements
- R1: Mode code 0 (immediate), and the unused codes 6 and 7, return the field itself as the operand, with access count 0 and reported address 0. They issue no memory request.
- R2: Mode code 1 (register) returns the register named by the selector, with access count 0 and reported address 0. It issues no memory request.
- R3: Mode code 2 (direct) issues one read at the low address bits of the field. The returned word is the operand, the reported address is the field address, and the count is 1.
- R4: Mode code 3 (indirect) reads a pointer at the field address, then reads the operand at that pointer. The reported address is the pointer and the count is 2.
- R5: Mode code 4 (indexed) forms the address as the field plus the selected register, with no extra read. It then makes one operand read, and the count is 1.
- R6: The register value is added as a signed number, so base 204 with index -8 (0xFFF8) gives address 196.
- R7: A zero index gives the same address and operand as direct mode on the same field.
- R8: Address sums keep only the low address bits, so with 8-bit addresses 250 + 10 gives address 4.
- R9: Mode code 5 (indexed-then-indirect) first adds field and index, then reads a pointer at that sum, then reads the operand at the pointer. The memory addresses appear in that order, and the count is 2.
- R10: After reset, done, busy and the memory request are low. Done is a one-cycle pulse. For modes with no memory access, done is high in the cycle after start.
- R11: A start pulse while busy is high is ignored: it does not change the running operation and does not cause a second result.
- R12: Each memory request is a one-cycle strobe. The next request, or done, waits for the read-valid response. With a single read of latency L extra cycles, done appears L+2 cycles after the request strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the specifier and begin |
| mode | input | 3 | Addressing mode code |
| field | input | DW | Constant or address field |
| reg_sel | input | RW | Register selector |
| rf_sel | output | RW | Register file read index |
| rf_data | input | DW | Register file read data (combinational) |
| mem_req | output | 1 | Memory read request strobe |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | Result valid pulse |
| operand | output | DW | Fetched operand |
| eff_addr | output | AW | Final effective address |
| acc_cnt | output | 2 | Memory accesses made |

## Verification
The bench builds the unit with 8-bit addresses, 16-bit data and eight registers. Because the address space is only 256 words, the whole memory fits in the bench model, and the carry wrap from 250 + 10 to 4 can be reached directly. Sixteen-bit data lets a negative index be stored as 0xFFF8 while the sum still truncates to 8 bits. The memory model can be given a different response delay for each operation, so the ordering of dependent reads and the timing of done are tested under more than one latency.

// File: rtl/opnd_fetch.sv
module opnd_fetch #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] field,
  input  logic [RW-1:0] reg_sel,
  output logic [RW-1:0] rf_sel,
  input  logic [DW-1:0] rf_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [AW-1:0] eff_addr,
  output logic [1:0]    acc_cnt
);
  localparam logic [2:0] M_REG = 3'd1;
  localparam logic [2:0] M_DIR = 3'd2;
  localparam logic [2:0] M_IND = 3'd3;
  localparam logic [2:0] M_IDX = 3'd4;
  localparam logic [2:0] M_IXI = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_WAIT1, S_WAIT2} st_t;
  st_t st;
  logic deref;

  logic uses_mem, uses_idx;
  logic [AW-1:0] first_addr;

  assign uses_mem   = (mode == M_DIR) || (mode == M_IND) || (mode == M_IDX) || (mode == M_IXI);
  assign uses_idx   = (mode == M_IDX) || (mode == M_IXI);
  assign first_addr = field[AW-1:0] + (uses_idx ? rf_data[AW-1:0] : '0);
  assign rf_sel     = reg_sel;
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      deref    <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      operand  <= '0;
      eff_addr <= '0;
      acc_cnt  <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            acc_cnt <= '0;
            if (uses_mem) begin
              mem_req  <= 1'b1;
              mem_addr <= first_addr;
              deref    <= (mode == M_IND) || (mode == M_IXI);
              st       <= S_WAIT1;
            end else begin
              done     <= 1'b1;
              operand  <= (mode == M_REG) ? rf_data : field;
              eff_addr <= '0;
            end
          end
        end
        S_WAIT1: begin
          if (mem_rvalid) begin
            acc_cnt <= 2'd1;
            if (deref) begin
              mem_req  <= 1'b1;
              mem_addr <= mem_rdata[AW-1:0];
              st       <= S_WAIT2;
            end else begin
              done     <= 1'b1;
              operand  <= mem_rdata;
              eff_addr <= mem_addr;
              st       <= S_IDLE;
            end
          end
        end
        S_WAIT2: begin
          if (mem_rvalid) begin
            acc_cnt  <= 2'd2;
            done     <= 1'b1;
            operand  <= mem_rdata;
            eff_addr <= mem_addr;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_fetch_chk.sv
module opnd_fetch_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic [DW-1:0] field,
  input logic [DW-1:0] rf_data,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] operand,
  input logic [AW-1:0] eff_addr,
  input logic [1:0]    acc_cnt
);
  assert_imm_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 3'd0) |=> (done && operand == $past(field) && acc_cnt == 2'd0 && eff_addr == '0));

  assert_reg_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 3'd1) |=> (done && operand == $past(rf_data) && acc_cnt == 2'd0 && !mem_req));

  assert_mem_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode >= 3'd2 && mode <= 3'd5) |=> (busy && mem_req && !done));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_cnt != 2'd3));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !mem_rvalid) |=> (!done && !mem_req));

  assert_req_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_waits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> !mem_req);
endmodule

bind opnd_fetch opnd_fetch_chk #(.AW(AW), .DW(DW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
  .rf_data(rf_data), .mem_req(mem_req), .mem_rvalid(mem_rvalid), .busy(busy),
  .done(done), .operand(operand), .eff_addr(eff_addr), .acc_cnt(acc_cnt)
);

// File: tb/opnd_fetch_tb_top.sv
`timescale 1ns/1ps
module opnd_fetch_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [DW-1:0] field = '0;
  logic [RW-1:0] reg_sel = '0;
  logic [RW-1:0] rf_sel;
  logic [DW-1:0] rf_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          busy, done;
  logic [DW-1:0] operand;
  logic [AW-1:0] eff_addr;
  logic [1:0]    acc_cnt;

  opnd_fetch #(.AW(AW), .DW(DW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .reg_sel(reg_sel), .rf_sel(rf_sel), .rf_data(rf_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .operand(operand), .eff_addr(eff_addr), .acc_cnt(acc_cnt)
  );

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] rf  [8];
  assign rf_data = rf[rf_sel];

  int lat = 0;
  int wcnt = 0;
  int reads = 0;
  logic pend = 1'b0;
  logic [AW-1:0] hold_addr = '0;
  logic [AW-1:0] rlog [4];

  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (wcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[hold_addr];
        pend       <= 1'b0;
      end else wcnt <= wcnt - 1;
    end else if (mem_req) begin
      pend      <= 1'b1;
      hold_addr <= mem_addr;
      wcnt      <= lat;
      if (reads < 4) rlog[reads] <= mem_addr;
      reads     <= reads + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [DW-1:0] f, input logic [RW-1:0] r,
                        input int l, output int cyc);
    @(negedge clk);
    lat = l; reads = 0; mode = m; field = f; reg_sel = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {mode, field, reg, latency, operand, eff_addr, count}
  localparam logic [51:0] VEC [11] = '{
    {3'd0, 16'd42,  3'd0, 4'd0, 16'd42,  8'd0,   2'd0},  // R1
    {3'd7, 16'd5,   3'd0, 4'd0, 16'd5,   8'd0,   2'd0},  // R1 unused code
    {3'd1, 16'd9,   3'd1, 4'd0, 16'd210, 8'd0,   2'd0},  // R2
    {3'd2, 16'd100, 3'd0, 4'd2, 16'd200, 8'd100, 2'd1},  // R3
    {3'd3, 16'd100, 3'd0, 4'd1, 16'd350, 8'd200, 2'd2},  // R4
    {3'd4, 16'd100, 3'd2, 4'd0, 16'd17,  8'd104, 2'd1},  // R5
    {3'd4, 16'd204, 3'd5, 4'd3, 16'd42,  8'd196, 2'd1},  // R6
    {3'd4, 16'd100, 3'd3, 4'd1, 16'd200, 8'd100, 2'd1},  // R7
    {3'd4, 16'd250, 3'd6, 4'd0, 16'd77,  8'd4,   2'd1},  // R8
    {3'd5, 16'd30,  3'd3, 4'd2, 16'd200, 8'd100, 2'd2},  // R9
    {3'd5, 16'd26,  3'd2, 4'd4, 16'd200, 8'd100, 2'd2}   // R9
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R1";
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int cyc;
    for (int a = 0; a < 256; a++) mem[a] = 16'(a * 5 + 3);
    mem[100] = 16'd200; mem[200] = 16'd350; mem[104] = 16'd17;
    mem[196] = 16'd42;  mem[4]   = 16'd77;  mem[30]  = 16'd100;
    for (int k = 0; k < 8; k++) rf[k] = 16'(k * 11);
    rf[1] = 16'd210; rf[2] = 16'd4; rf[3] = 16'd0; rf[5] = 16'hFFF8; rf[6] = 16'd10;

    repeat (3) @(negedge clk);
    chk("R10", "reset done", 32'(done), 0);
    chk("R10", "reset busy", 32'(busy), 0);
    chk("R10", "reset mem_req", 32'(mem_req), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      logic [51:0] v;
      v = VEC[i];
      run_op(v[51:49], v[48:33], v[32:30], int'(v[29:26]), cyc);
      chk(tag_of(i), "done seen", 32'(done), 1);
      chk(tag_of(i), "operand", 32'(operand), 32'(v[25:10]));
      chk(tag_of(i), "eff_addr", 32'(eff_addr), 32'(v[9:2]));
      chk(tag_of(i), "acc_cnt", 32'(acc_cnt), 32'(v[1:0]));
      chk(tag_of(i), "reads issued", 32'(reads), 32'(v[1:0]));
      if (i == 9) begin
        chk("R9", "first read addr", 32'(rlog[0]), 30);
        chk("R9", "second read addr", 32'(rlog[1]), 100);
      end
    end

    // R10: immediate result the cycle after start, then done drops
    run_op(3'd0, 16'd1234, 3'd0, 0, cyc);
    chk("R10", "imm done latency", 32'(cyc), 1);
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done), 0);

    // R12: single read latency tracks memory delay
    run_op(3'd2, 16'd104, 3'd0, 9, cyc);
    chk("R12", "slow read cycles", 32'(cyc), 12);
    chk("R12", "slow read operand", 32'(operand), 17);
    run_op(3'd3, 16'd100, 3'd0, 1, cyc);
    chk("R12", "two-read cycles", 32'(cyc), 7);

    // R11: start while busy is ignored
    @(negedge clk);
    lat = 4; reads = 0; mode = 3'd5; field = 16'd30; reg_sel = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mode = 3'd0; field = 16'd999; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R11", "operand kept", 32'(operand), 200);
    chk("R11", "count kept", 32'(acc_cnt), 2);
    chk("R11", "reads", 32'(reads), 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11", "no second result", 32'(done), 0);
    end

    summary();
    $finish;
  end
endmodule